// File: doc/BRIEF.md
# Bit-Serial Instruction Phase Sequencer

This block supplies the timing frame of a bit-serial processor driven by a single master clock. Every operand bit is handled over a small group of clock cycles, so the sequencer runs three cascaded counters: a sub-bit counter, a bit index within a phase, and a phase number within an instruction. From these counters it derives strobes that mark where each phase begins and ends. It also produces one access strobe per phase: phase 0 fetches the instruction, and phases 1 and 2 read the low and high operand syllables. With the default parameters a basic instruction lasts 4 x 14 x 3 = 168 clocks.

The block also decodes the instruction. The opcode field has 4 bits but there are 18 instructions, so one opcode value is shared. Two operand address bits pick which of the three sharing instructions is meant. The decoded identifier is captured once, on the last clock of the fetch phase, and is held for the rest of the instruction.

Long operations such as multiply and divide ask for more time through an extend input. An extension repeats the whole phase sequence for a programmed number of passes. No memory access strobe fires during these passes. When they are done the next fetch follows.

Top module: `serial_phase_seq`

## Requirements
- R1: While reset is asserted, sub_cnt_o, bit_idx_o and phase_o are 0, instr_id_o is 0 and ext_active_o is 0. As a result phase_start_o is 1 and access_stb_o is 3'b001.
- R2: sub_cnt_o increments by one on every clock from 0 to SUB_N-1 (default 3) and then wraps to 0.
- R3: bit_idx_o advances by one on the clock after sub_cnt_o is SUB_N-1. It runs 0 to BIT_N-1 (default 13) and wraps to 0; otherwise it holds.
- R4: phase_o advances on the clock after sub_cnt_o=SUB_N-1 with bit_idx_o=BIT_N-1, and cycles 0,1,2,0. A basic instruction therefore spans 168 clocks.
- R5: phase_start_o is 1 exactly when sub_cnt_o=0 and bit_idx_o=0. phase_end_o is 1 exactly when sub_cnt_o=SUB_N-1 and bit_idx_o=BIT_N-1.
- R6: access_stb_o bit p is 1 only on the first clock of phase p of a normal (non-extension) pass. Bit 0 is the instruction fetch, bit 1 the low operand syllable and bit 2 the high operand syllable. At most one bit is ever set, and all bits are 0 while ext_active_o is 1.
- R7: The decoder maps opcode values 0 to 14 to the identifier equal to the opcode. Opcode 15 is shared: addr_sel_i 0 gives 15, 1 gives 16, and 2 or 3 gives 17. There are 18 identifiers (0 to 17) in total.
- R8: instr_id_o loads the decoded value of opcode_i and addr_sel_i on the last clock of phase 0 of a normal pass, and holds at every other clock.
- R9: If extend_i=1 and ext_count_i=N>0 on the last clock of phase 2 of a normal pass, ext_active_o is 1 for exactly N complete 168-clock passes. It then returns to 0 and a normal pass (with its fetch) follows. ext_count_i is sampled only at that clock.
- R10: extend_i has no effect when ext_count_i is 0, at any clock other than the last clock of phase 2, or during an extension pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 4 | Opcode field of the instruction being fetched |
| addr_sel_i | input | 2 | Operand address bits that resolve the shared opcode |
| extend_i | input | 1 | Request for extra instruction passes |
| ext_count_i | input | EXT_W (4) | Number of extra passes requested |
| sub_cnt_o | output | 2 | Clock within the current bit time |
| bit_idx_o | output | 4 | Bit index within the current phase |
| phase_o | output | 2 | Phase within the instruction pass |
| phase_start_o | output | 1 | First clock of a phase |
| phase_end_o | output | 1 | Last clock of a phase |
| access_stb_o | output | 3 | Fetch / low syllable / high syllable strobes |
| instr_id_o | output | 5 | Registered instruction identifier |
| ext_active_o | output | 1 | An extension pass is in progress |

## Verification
The bench keeps the default frame of 4 clocks, 14 bits and 3 phases, and builds the block with EXT_W=3. The narrower count lets every extension length from 0 to 7 be swept in a few thousand clocks. The full 168-clock frame is checked on every clock against a counter model kept in the bench. All 64 combinations of opcode and selector bits are latched in turn, with scrambled inputs on every non-latching clock. Separate runs drive extend during non-sampling clocks and vary the count during extension passes, to show that neither has any effect.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OPC_W     = 4;
  localparam int SEL_W     = 2;
  localparam int NUM_IDS   = 18;
  localparam int ID_W      = $clog2(NUM_IDS);
  localparam int SHARED_OP = (1 << OPC_W) - 1;

  // Expand opcode plus selector into an instruction identifier.
  function automatic logic [ID_W-1:0] decode_op(input logic [OPC_W-1:0] op,
                                                input logic [SEL_W-1:0] sel);
    logic [ID_W-1:0] id;
    if (op != OPC_W'(SHARED_OP)) begin
      id = ID_W'(op);
    end else if (sel >= SEL_W'(2)) begin
      id = ID_W'(SHARED_OP + 2);
    end else begin
      id = ID_W'(SHARED_OP) + ID_W'(sel);
    end
    return id;
  endfunction
endpackage

// File: rtl/seq_bit_timer.sv
module seq_bit_timer #(
  parameter int SUB_N = 4,
  parameter int BIT_N = 14,
  parameter int PH_N  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [$clog2(SUB_N)-1:0] sub_o,
  output logic [$clog2(BIT_N)-1:0] bit_o,
  output logic [$clog2(PH_N)-1:0]  ph_o,
  output logic                     bit_tick_o,
  output logic                     phase_start_o,
  output logic                     phase_end_o,
  output logic                     pass_end_o
);
  localparam int SUB_W = $clog2(SUB_N);
  localparam int BIT_W = $clog2(BIT_N);
  localparam int PH_W  = $clog2(PH_N);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_N - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BIT_N - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PH_N - 1);

  assign bit_tick_o    = (sub_o == SUB_LAST);
  assign phase_end_o   = bit_tick_o && (bit_o == BIT_LAST);
  assign pass_end_o    = phase_end_o && (ph_o == PH_LAST);
  assign phase_start_o = (sub_o == '0) && (bit_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_o <= '0;
      bit_o <= '0;
      ph_o  <= '0;
    end else begin
      sub_o <= bit_tick_o ? '0 : sub_o + 1'b1;
      if (bit_tick_o) begin
        bit_o <= phase_end_o ? '0 : bit_o + 1'b1;
      end
      if (phase_end_o) begin
        ph_o <= pass_end_o ? '0 : ph_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_ext_ctl.sv
module seq_ext_ctl #(
  parameter int EXT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pass_end_i,
  input  logic             extend_i,
  input  logic [EXT_W-1:0] count_i,
  output logic             active_o
);
  logic [EXT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      left_q   <= '0;
    end else if (pass_end_i) begin
      if (!active_o) begin
        if (extend_i && (count_i != '0)) begin
          active_o <= 1'b1;
          left_q   <= count_i;
        end
      end else if (left_q == EXT_W'(1)) begin
        active_o <= 1'b0;
        left_q   <= '0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_op_latch.sv
module seq_op_latch
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [ID_W-1:0]  id_o
);
  logic [ID_W-1:0] id_next;

  assign id_next = decode_op(opcode_i, sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_o <= '0;
    end else if (load_i) begin
      id_o <= id_next;
    end
  end
endmodule

// File: rtl/serial_phase_seq.sv
module serial_phase_seq
  import seq_pkg::*;
#(
  parameter int SUB_N = 4,
  parameter int BIT_N = 14,
  parameter int PH_N  = 3,
  parameter int EXT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [OPC_W-1:0]         opcode_i,
  input  logic [SEL_W-1:0]         addr_sel_i,
  input  logic                     extend_i,
  input  logic [EXT_W-1:0]         ext_count_i,
  output logic [$clog2(SUB_N)-1:0] sub_cnt_o,
  output logic [$clog2(BIT_N)-1:0] bit_idx_o,
  output logic [$clog2(PH_N)-1:0]  phase_o,
  output logic                     phase_start_o,
  output logic                     phase_end_o,
  output logic [PH_N-1:0]          access_stb_o,
  output logic [ID_W-1:0]          instr_id_o,
  output logic                     ext_active_o
);
  localparam int PH_W = $clog2(PH_N);

  // Internal events, named for the checker
  logic bit_tick;
  logic pass_end;
  logic id_load;

  seq_bit_timer #(.SUB_N(SUB_N), .BIT_N(BIT_N), .PH_N(PH_N)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .sub_o         (sub_cnt_o),
    .bit_o         (bit_idx_o),
    .ph_o          (phase_o),
    .bit_tick_o    (bit_tick),
    .phase_start_o (phase_start_o),
    .phase_end_o   (phase_end_o),
    .pass_end_o    (pass_end)
  );

  seq_ext_ctl #(.EXT_W(EXT_W)) u_ext (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass_end_i (pass_end),
    .extend_i   (extend_i),
    .count_i    (ext_count_i),
    .active_o   (ext_active_o)
  );

  assign id_load = phase_end_o && (phase_o == '0) && !ext_active_o;

  seq_op_latch u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (id_load),
    .opcode_i (opcode_i),
    .sel_i    (addr_sel_i),
    .id_o     (instr_id_o)
  );

  // One access strobe per phase, only in normal passes
  for (genvar p = 0; p < PH_N; p++) begin : g_acc
    assign access_stb_o[p] = phase_start_o && !ext_active_o && (phase_o == PH_W'(p));
  end
endmodule

// File: rtl/seq_chk.sv
module seq_chk
  import seq_pkg::*;
#(
  parameter int SUB_N = 4,
  parameter int BIT_N = 14,
  parameter int PH_N  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [$clog2(SUB_N)-1:0] sub,
  input logic [$clog2(BIT_N)-1:0] bitx,
  input logic [$clog2(PH_N)-1:0]  ph,
  input logic                     pstart,
  input logic                     pend,
  input logic                     pass_end,
  input logic                     id_load,
  input logic [PH_N-1:0]          acc,
  input logic [ID_W-1:0]          id,
  input logic                     ext_act
);
  localparam int SUB_W = $clog2(SUB_N);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_N - 1);

  // R2
  sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub != SUB_LAST) |=> (sub == SUB_W'($past(sub) + 1)));
  // R2
  sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub == SUB_LAST) |=> (sub == '0));
  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub != SUB_LAST) |=> $stable(bitx));
  // R3
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bitx) < BIT_N);
  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> $stable(ph));
  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ph) < PH_N);
  // R5
  end_then_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> pstart);
  // R6
  acc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc));
  // R6
  acc_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc != '0) |-> (pstart && !ext_act));
  // R7
  id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(id) < NUM_IDS);
  // R8
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_load |=> $stable(id));
  // R9
  ext_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_act) |-> $past(pass_end));
  // R10
  ext_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_act) |-> $past(pass_end));
endmodule

bind serial_phase_seq seq_chk #(.SUB_N(SUB_N), .BIT_N(BIT_N), .PH_N(PH_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sub      (sub_cnt_o),
  .bitx     (bit_idx_o),
  .ph       (phase_o),
  .pstart   (phase_start_o),
  .pend     (phase_end_o),
  .pass_end (pass_end),
  .id_load  (id_load),
  .acc      (access_stb_o),
  .id       (instr_id_o),
  .ext_act  (ext_active_o)
);

// File: tb/tb_serial_phase_seq.sv
`timescale 1ns/1ps
module tb_serial_phase_seq;
  localparam int EW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    opcode_i = '0;
  logic [1:0]    addr_sel_i = '0;
  logic          extend_i = 1'b0;
  logic [EW-1:0] ext_count_i = '0;
  logic [1:0]    sub_cnt_o;
  logic [3:0]    bit_idx_o;
  logic [1:0]    phase_o;
  logic          phase_start_o, phase_end_o;
  logic [2:0]    access_stb_o;
  logic [4:0]    instr_id_o;
  logic          ext_active_o;

  int total = 0;
  int bad = 0;

  // Bench model state
  int ms = 0, mb = 0, mp = 0, mid = 0, mleft = 0;
  bit mact = 1'b0;

  always #5 clk = ~clk;

  serial_phase_seq #(.EXT_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .addr_sel_i(addr_sel_i),
    .extend_i(extend_i), .ext_count_i(ext_count_i), .sub_cnt_o(sub_cnt_o),
    .bit_idx_o(bit_idx_o), .phase_o(phase_o), .phase_start_o(phase_start_o),
    .phase_end_o(phase_end_o), .access_stb_o(access_stb_o),
    .instr_id_o(instr_id_o), .ext_active_o(ext_active_o)
  );

  function automatic int exp_id(int op, int sel);
    if (op < 15) return op;
    return 15 + ((sel > 2) ? 2 : sel);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_pend();
    return (ms == 3) && (mb == 13);
  endfunction

  // Check outputs, drive inputs, advance model by one clock.
  task automatic step(int op, int sel, bit ext, int cnt, string idtag, string xtag);
    bit ps, pe;
    int acc;
    ps  = (ms == 0) && (mb == 0);
    pe  = m_pend();
    acc = (ps && !mact) ? (1 << mp) : 0;
    chk("R2 sub_cnt", int'(sub_cnt_o), ms);
    chk("R3 bit_idx", int'(bit_idx_o), mb);
    chk("R4 phase", int'(phase_o), mp);
    chk("R5 phase_start", int'(phase_start_o), int'(ps));
    chk("R5 phase_end", int'(phase_end_o), int'(pe));
    chk("R6 access_stb", int'(access_stb_o), acc);
    chk(idtag, int'(instr_id_o), mid);
    chk(xtag, int'(ext_active_o), int'(mact));
    opcode_i    = 4'(op);
    addr_sel_i  = 2'(sel);
    extend_i    = ext;
    ext_count_i = EW'(cnt);
    if (pe && mp == 0 && !mact) mid = exp_id(op & 15, sel & 3);
    if (pe && mp == 2) begin
      if (!mact) begin
        if (ext && (cnt != 0)) begin mact = 1'b1; mleft = cnt; end
      end else if (mleft == 1) begin
        mact = 1'b0;
      end else begin
        mleft--;
      end
    end
    if (ms == 3) begin
      if (pe) mp = (mp == 2) ? 0 : mp + 1;
      mb = (mb == 13) ? 0 : mb + 1;
    end
    ms = (ms + 1) % 4;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #3000000;
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int t;
    t = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 sub_cnt", int'(sub_cnt_o), 0);
    chk("R1 bit_idx", int'(bit_idx_o), 0);
    chk("R1 phase", int'(phase_o), 0);
    chk("R1 phase_start", int'(phase_start_o), 1);
    chk("R1 access_stb", int'(access_stb_o), 1);
    chk("R1 instr_id", int'(instr_id_o), 0);
    chk("R1 ext_active", int'(ext_active_o), 0);
    rst_n = 1'b1;

    // R7 R8: all opcode/selector pairs, scrambled inputs off the latch clock,
    // extend toggling with a zero count (R10)
    for (int combo = 0; combo < 64; combo++) begin
      for (int k = 0; k < 168; k++) begin
        bit ld;
        ld = m_pend() && (mp == 0) && !mact;
        t++;
        if (ld) step(combo >> 2, combo & 3, k[0], 0, "R7 R8 instr_id", "R10 ext_active");
        else    step((t * 5 + 3) & 15, (t * 3) & 3, k[0], 0, "R8 instr_id", "R10 ext_active");
      end
    end

    // R9: every extension length, count changed during extension passes
    for (int n = 0; n < 8; n++) begin
      for (int c = 0; c < (1 + n) * 336; c++) begin
        t++;
        step((t * 7) & 15, t & 3, 1'b1, mact ? ((n + 3) & 7) : n, "R8 instr_id", "R9 ext_active");
      end
    end

    // Let any extension finish, then R10: extend pulsed off the sampling clock
    for (int k = 0; k < 8 * 168; k++) begin
      t++;
      step(t & 15, 0, 1'b0, 0, "R8 instr_id", "R9 ext_active");
    end
    for (int k = 0; k < 3 * 168; k++) begin
      bit smp;
      smp = m_pend() && (mp == 2);
      t++;
      step(t & 15, 1, !smp, 5, "R8 instr_id", "R10 ext_active");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule